// File: doc/BRIEF.md
# Frame Check Sequence Unit

This block produces and verifies the 16-bit check sequence carried at the tail of every 802.15.4 frame. It sits on two byte-serial streams, one outbound and one inbound. Each stream marks bytes with a valid strobe, flags the first and last byte of a frame, and supplies the declared frame length alongside the first byte.

On the outbound side, automatic generation may be switched on per frame. When it is, the unit runs the CRC over the leading N-2 payload bytes of an N-byte frame. It then overwrites the final two byte slots with the result, low byte first. The frame keeps its declared length: no bytes are inserted. When generation is off, or the frame is too short to hold a check sequence, every byte passes through untouched.

On the inbound side, the CRC runs over every byte, check bytes included. When the last byte arrives, a single pass/fail bit is latched. The bit is set only if the remainder is zero and the declared length is at least two.

Top module: `fcs_unit`

## Requirements
- R1: The CRC uses the polynomial x^16+x^12+x^5+1, starts from zero at each frame start, and takes each byte least significant bit first. In the right-shifting form this means: per bit, feedback = crc[0] xor data bit; crc shifts right by one; crc is xored with 0x8408 when feedback is 1. The check string "123456789" leaves 0x2189.
- R2: With generation on and declared length N >= 2, output bytes 0 to N-3 equal the input bytes at the same positions.
- R3: With generation on and N >= 2, the output byte at position N-2 is bits 7:0 of the CRC over bytes 0 to N-3. The output byte at position N-1 is bits 15:8 of that CRC. The input bytes in those two slots are discarded.
- R4: With generation off, every output byte equals its input byte. The enable and the length are both sampled only on the start-of-frame byte; their values on later bytes have no effect.
- R5: A transmit frame with declared length 0 or 1 passes through unchanged, whatever the enable says.
- R6: Each outbound byte, with its valid, start and end flags, appears on the outputs exactly one clock after it is accepted.
- R7: One clock after the inbound end-of-frame byte, rx_done_o pulses for one cycle. At the same time rx_crc_ok_o shows 1 exactly when the CRC over all received bytes is zero.
- R8: An inbound frame whose declared length is 0 or 1 always reports fail.
- R9: rx_crc_ok_o is 0 after reset. It changes only together with an rx_done_o pulse and otherwise holds its value.
- R10: The length field is 7 bits wide, so the largest frame is 127 bytes; a 127-byte frame is handled like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_crc_en_i | input | 1 | Automatic check generation enable, sampled at frame start |
| tx_valid_i | input | 1 | Outbound byte valid |
| tx_sof_i | input | 1 | Outbound first byte of frame |
| tx_eof_i | input | 1 | Outbound last byte of frame |
| tx_data_i | input | 8 | Outbound byte |
| tx_len_i | input | 7 | Outbound declared length, sampled at frame start |
| tx_valid_o | output | 1 | Delayed byte valid |
| tx_sof_o | output | 1 | Delayed first-byte flag |
| tx_eof_o | output | 1 | Delayed last-byte flag |
| tx_data_o | output | 8 | Byte after check substitution |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_sof_i | input | 1 | Inbound first byte of frame |
| rx_eof_i | input | 1 | Inbound last byte of frame |
| rx_data_i | input | 8 | Inbound byte |
| rx_len_i | input | 7 | Inbound declared length, sampled at frame start |
| rx_done_o | output | 1 | One-cycle pulse after the inbound last byte |
| rx_crc_ok_o | output | 1 | Latched pass/fail of the last inbound frame |

## Verification
An outbound byte accepted at one rising edge is on tx_data_o after the next rising edge. The bench therefore drives each byte at a falling edge and compares the output at the following falling edge, without leaving a gap between bytes. The inbound verdict and the done pulse are due one edge after the end-of-frame byte, so they are sampled at the falling edge right after that byte. The status is sampled again after idle cycles to show that it holds. The length sweeps cover every value from 0 to 40, plus long frames up to 127 bytes. Expected outbound bytes and clean inbound check sequences come from a CRC routine in the bench. Corrupted inbound frames carry a single flipped bit.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 16;
  localparam int LEN_W = 7;
  // x^16+x^12+x^5+1, bit-reversed for LSB-first shifting
  localparam logic [CRC_W-1:0] POLY_REV = 16'h8408;
endpackage

// File: rtl/fcs_crc_byte.sv
module fcs_crc_byte #(
  parameter int CRC_W = fcs_pkg::CRC_W,
  parameter int DATA_W = fcs_pkg::BYTE_W,
  parameter logic [CRC_W-1:0] POLY = fcs_pkg::POLY_REV
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stg [DATA_W+1];

  assign stg[0] = crc_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb = stg[b][0] ^ data_i[b];
    assign stg[b+1] = (stg[b] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_o = stg[DATA_W];
endmodule

// File: rtl/fcs_tx.sv
module fcs_tx #(
  parameter int DATA_W = fcs_pkg::BYTE_W,
  parameter int CRC_W = fcs_pkg::CRC_W,
  parameter int LEN_W = fcs_pkg::LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = LEN_W'((1 << LEN_W) - 1);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

  logic [LEN_W-1:0] cnt_q, len_q;
  logic             en_q;
  logic [CRC_W-1:0] crc_q;

  logic [LEN_W-1:0] cnt_cur, len_cur, lo_idx, hi_idx;
  logic             en_cur, sub_on, in_tail;
  logic [CRC_W-1:0] crc_cur, crc_upd;
  logic [DATA_W-1:0] data_nx;

  assign cnt_cur = sof_i ? '0 : cnt_q;
  assign len_cur = sof_i ? len_i : len_q;
  assign en_cur  = sof_i ? en_i : en_q;
  assign crc_cur = sof_i ? '0 : crc_q;

  assign lo_idx  = len_cur - LEN_W'(2);
  assign hi_idx  = len_cur - LEN_W'(1);
  assign sub_on  = en_cur && (len_cur >= MIN_LEN);
  assign in_tail = sub_on && (cnt_cur >= lo_idx);

  fcs_crc_byte #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_crc (
    .crc_i (crc_cur),
    .data_i(data_i),
    .crc_o (crc_upd)
  );

  always_comb begin
    data_nx = data_i;
    if (sub_on && cnt_cur == lo_idx)      data_nx = crc_cur[DATA_W-1:0];
    else if (sub_on && cnt_cur == hi_idx) data_nx = crc_cur[CRC_W-1:DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
      en_q  <= 1'b0;
      crc_q <= '0;
    end else if (valid_i) begin
      cnt_q <= (cnt_cur == CNT_MAX) ? CNT_MAX : cnt_cur + LEN_W'(1);
      len_q <= len_cur;
      en_q  <= en_cur;
      crc_q <= in_tail ? crc_cur : crc_upd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      sof_o   <= valid_i && sof_i;
      eof_o   <= valid_i && eof_i;
      if (valid_i) data_o <= data_nx;
    end
  end

  AST_TX_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_TX_EOF_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i) |=> eof_o); // R6
  AST_TX_PASS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !en_cur) |=> (data_o == $past(data_i))); // R4
  AST_TX_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && len_cur < MIN_LEN) |=> (data_o == $past(data_i))); // R5
  AST_TX_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_on && cnt_cur < lo_idx) |=> (data_o == $past(data_i))); // R2
endmodule

// File: rtl/fcs_rx.sv
module fcs_rx #(
  parameter int DATA_W = fcs_pkg::BYTE_W,
  parameter int CRC_W = fcs_pkg::CRC_W,
  parameter int LEN_W = fcs_pkg::LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              done_o,
  output logic              ok_o
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

  logic [CRC_W-1:0] crc_q, crc_cur, crc_upd;
  logic [LEN_W-1:0] len_q, len_cur;

  assign crc_cur = sof_i ? '0 : crc_q;
  assign len_cur = sof_i ? len_i : len_q;

  fcs_crc_byte #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_crc (
    .crc_i (crc_cur),
    .data_i(data_i),
    .crc_o (crc_upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '0;
      len_q  <= '0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
    end else begin
      done_o <= valid_i && eof_i;
      if (valid_i) begin
        crc_q <= crc_upd;
        len_q <= len_cur;
        if (eof_i) ok_o <= (crc_upd == '0) && (len_cur >= MIN_LEN);
      end
    end
  end

  AST_RX_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i) |=> done_o); // R7
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ok_o)); // R9
  AST_RX_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i && len_cur < MIN_LEN) |=> !ok_o); // R8
endmodule

// File: rtl/fcs_unit.sv
module fcs_unit
  import fcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_crc_en_i,
  input  logic              tx_valid_i,
  input  logic              tx_sof_i,
  input  logic              tx_eof_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  output logic              tx_valid_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  output logic              rx_done_o,
  output logic              rx_crc_ok_o
);
  fcs_tx #(.DATA_W(BYTE_W), .CRC_W(CRC_W), .LEN_W(LEN_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_crc_en_i),
    .valid_i(tx_valid_i),
    .sof_i  (tx_sof_i),
    .eof_i  (tx_eof_i),
    .data_i (tx_data_i),
    .len_i  (tx_len_i),
    .valid_o(tx_valid_o),
    .sof_o  (tx_sof_o),
    .eof_o  (tx_eof_o),
    .data_o (tx_data_o)
  );

  fcs_rx #(.DATA_W(BYTE_W), .CRC_W(CRC_W), .LEN_W(LEN_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rx_valid_i),
    .sof_i  (rx_sof_i),
    .eof_i  (rx_eof_i),
    .data_i (rx_data_i),
    .len_i  (rx_len_i),
    .done_o (rx_done_o),
    .ok_o   (rx_crc_ok_o)
  );
endmodule

// File: tb/fcs_unit_bench.sv
module fcs_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_crc_en_i = 1'b0, tx_valid_i = 1'b0, tx_sof_i = 1'b0, tx_eof_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic [6:0] tx_len_i = '0;
  logic tx_valid_o, tx_sof_o, tx_eof_o;
  logic [7:0] tx_data_o;
  logic rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic [6:0] rx_len_i = '0;
  logic rx_done_o, rx_crc_ok_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] frm [128];
  logic [7:0] expv [128];
  logic [7:0] got [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcs_unit u_fcs_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_crc_en_i(tx_crc_en_i), .tx_valid_i(tx_valid_i), .tx_sof_i(tx_sof_i),
    .tx_eof_i(tx_eof_i), .tx_data_i(tx_data_i), .tx_len_i(tx_len_i),
    .tx_valid_o(tx_valid_o), .tx_sof_o(tx_sof_o), .tx_eof_o(tx_eof_o),
    .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i), .rx_eof_i(rx_eof_i),
    .rx_data_i(rx_data_i), .rx_len_i(rx_len_i),
    .rx_done_o(rx_done_o), .rx_crc_ok_o(rx_crc_ok_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ frm[i][b];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  // Drives frm[0..] as one outbound frame; checks each byte one clock later.
  task automatic drive_tx(input int len, input bit en);
    int nb;
    logic [15:0] c;
    nb = (len < 1) ? 1 : len;
    for (int p = 0; p < nb; p++) expv[p] = frm[p];
    if (en && len >= 2) begin
      c = crc_of(len - 2);
      expv[len-2] = c[7:0];
      expv[len-1] = c[15:8];
    end
    @(negedge clk);
    for (int p = 0; p < nb; p++) begin
      tx_valid_i = 1'b1;
      tx_sof_i = (p == 0);
      tx_eof_i = (p == nb - 1);
      tx_data_i = frm[p];
      tx_len_i = (p == 0) ? 7'(len) : 7'h55;   // junk after start: R4
      tx_crc_en_i = (p == 0) ? en : ~en;
      @(negedge clk);
      got[p] = tx_data_o;
      check(tx_valid_o == 1'b1, "R6 valid", tx_valid_o, 1);
      check(tx_sof_o == (p == 0), "R6 sof", tx_sof_o, (p == 0));
      check(tx_eof_o == (p == nb - 1), "R6 eof", tx_eof_o, (p == nb - 1));
      if (len < 2)
        check(tx_data_o == expv[p], "R5 short passthrough", tx_data_o, expv[p]);
      else if (!en)
        check(tx_data_o == expv[p], "R4 disabled passthrough", tx_data_o, expv[p]);
      else if (p < len - 2)
        check(tx_data_o == expv[p], "R2 payload", tx_data_o, expv[p]);
      else
        check(tx_data_o == expv[p], "R3 fcs byte", tx_data_o, expv[p]);
    end
    tx_valid_i = 1'b0; tx_sof_i = 1'b0; tx_eof_i = 1'b0;
    @(negedge clk);
    check(tx_valid_o == 1'b0, "R6 idle", tx_valid_o, 0);
  endtask

  task automatic fill(input int n, input int seed);
    for (int p = 0; p < n; p++) frm[p] = 8'((p * 29 + seed * 7 + 3) & 255);
  endtask

  task automatic drive_rx(input int len, input bit corrupt, input int seed);
    int nb;
    bit exp_ok;
    logic [15:0] c;
    logic prev;
    nb = (len < 1) ? 1 : len;
    fill(nb, seed);
    if (len >= 2) begin
      c = crc_of(len - 2);
      frm[len-2] = c[7:0];
      frm[len-1] = c[15:8];
    end
    if (corrupt) frm[seed % nb] = frm[seed % nb] ^ 8'(1 << (seed % 8));
    exp_ok = (len >= 2) && !corrupt;
    @(negedge clk);
    for (int p = 0; p < nb; p++) begin
      rx_valid_i = 1'b1;
      rx_sof_i = (p == 0);
      rx_eof_i = (p == nb - 1);
      rx_data_i = frm[p];
      rx_len_i = (p == 0) ? 7'(len) : 7'h2A;
      @(negedge clk);
      if (p < nb - 1) check(rx_done_o == 1'b0, "R7 no early done", rx_done_o, 0);
    end
    rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
    check(rx_done_o == 1'b1, "R7 done pulse", rx_done_o, 1);
    if (len < 2) check(rx_crc_ok_o == 1'b0, "R8 short fails", rx_crc_ok_o, 0);
    else check(rx_crc_ok_o == exp_ok, "R7 verdict", rx_crc_ok_o, exp_ok);
    prev = rx_crc_ok_o;
    repeat (2) @(negedge clk);
    check(rx_done_o == 1'b0, "R7 pulse ends", rx_done_o, 0);
    check(rx_crc_ok_o == prev, "R9 status holds", rx_crc_ok_o, prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid_o == 1'b0, "R6 reset valid", tx_valid_o, 0);
    check(rx_done_o == 1'b0, "R7 reset done", rx_done_o, 0);
    check(rx_crc_ok_o == 1'b0, "R9 reset status", rx_crc_ok_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: known check value of "123456789"
    for (int i = 0; i < 9; i++) frm[i] = 8'(8'h31 + i);
    frm[9] = 8'hEE; frm[10] = 8'hEE;
    drive_tx(11, 1'b1);
    check(got[9] == 8'h89, "R1 check low byte", got[9], 8'h89);
    check(got[10] == 8'h21, "R1 check high byte", got[10], 8'h21);

    for (int len = 0; len <= 40; len++) begin
      for (int en = 0; en < 2; en++) begin
        fill((len < 1) ? 1 : len, len + en);
        drive_tx(len, en[0]);
      end
    end
    // R10: long frames up to the 7-bit maximum
    for (int k = 0; k < 4; k++) begin
      int len;
      len = (k == 0) ? 64 : (k == 1) ? 100 : (k == 2) ? 126 : 127;
      fill(len, k);
      drive_tx(len, 1'b1);
      check(1'b1, "R10 long frame sent", len, len);
    end

    for (int len = 0; len <= 40; len++) begin
      drive_rx(len, 1'b0, len + 5);
      drive_rx(len, 1'b1, len * 3 + 1);
    end
    drive_rx(127, 1'b0, 9);   // R10
    drive_rx(127, 1'b1, 77);  // R10
    drive_rx(2, 1'b0, 4);     // R9: pass after a fail
    drive_rx(1, 1'b0, 4);     // R8

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule